// File: doc/BRIEF.md
# Parity-Protected AHB-Lite GPIO Port

This block is a memory-mapped general-purpose I/O port that sits on an AHB-Lite slave bus. Software programs a single direction bit and an output data word. When the port is set to drive, the data word appears on the output pins. The port always adds one protection bit to that word. On the input side, the port samples the pin word together with its incoming protection bit and flags any word whose parity does not match.

One input pin selects the parity sense for both directions, even or odd. A fault-injection input lets a test corrupt the outgoing protection bit and invert the error flag, so that downstream checkers and this port's own error path can be exercised on purpose.

The bus side takes no wait states. Transfers are captured in the address phase and act in the data phase. Only word-aligned offsets 0x0 (data) and 0x4 (direction) are decoded.

Top module: `gpio_parity_ahb`

## Requirements
- R1: `hreadyout` is 1 and `hresp` is 0 (OKAY) in every cycle.
- R2: After reset, `pin_out` is all zeros, `pin_oe` is 0 (input direction) and `parity_err` is 0.
- R3: Bit DW of `pin_out` is the parity bit over `pin_out[DW-1:0]`. With `odd_parity`=0 the total count of ones in `pin_out[DW:0]` is even; with `odd_parity`=1 it is odd. The bit follows a change of `odd_parity` one clock later.
- R4: While `fault_inj` is 1, the driven parity bit `pin_out[DW]` is the inverse of the value R3 gives, one clock later.
- R5: `parity_err` is registered. One clock after `pin_in` is sampled, it equals 1 when the ones count of `pin_in[DW:0]` (data bits plus the parity bit at index DW) is odd with `odd_parity`=0, or even with `odd_parity`=1. A 1 on `fault_inj` inverts this result.
- R6: A write to offset 0x0 while the direction bit is 1 places `hwdata[DW-1:0]` on `pin_out[DW-1:0]` at the clock edge that ends the data phase, together with its parity bit.
- R7: A write to offset 0x0 while the direction bit is 0 is ignored. `pin_out` keeps its value, including after the direction bit is later set to 1.
- R8: A write to offset 0x4 loads the direction bit from `hwdata[0]` (1 = output). `pin_oe` shows it, and a read of 0x4 returns it in bit 0 with all other bits 0.
- R9: A read of offset 0x0 returns `pin_in[DW-1:0]`, sampled at the end of the address phase, when the direction bit is 0. It returns the output data word when the direction bit is 1. Upper bits are 0 in both cases.
- R10: Any other offset, including a misaligned one, reads as 0, and writes to it change nothing.
- R11: A transfer happens only when `hsel` and `hready` are both 1 and `htrans` is NONSEQ (2'b10) or SEQ (2'b11). IDLE and BUSY cycles change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Active-low asynchronous reset |
| hsel | input | 1 | Slave select |
| haddr | input | AW | Byte address within the block |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 = write transfer |
| hready | input | 1 | Bus-wide ready; 1 lets an address phase complete |
| hwdata | input | 32 | Write data, valid in the data phase |
| hrdata | output | 32 | Read data, valid in the data phase |
| hreadyout | output | 1 | Slave ready, fixed at 1 |
| hresp | output | 1 | Slave response, fixed at OKAY |
| odd_parity | input | 1 | 0 = even parity, 1 = odd parity, for both directions |
| fault_inj | input | 1 | Inverts the generated parity bit and the error flag |
| pin_in | input | DW+1 | Incoming pin word; bit DW is its parity bit |
| pin_out | output | DW+1 | Driven pin word; bit DW is the generated parity bit |
| pin_oe | output | 1 | Direction bit, 1 = port drives its pins |
| parity_err | output | 1 | Registered input parity error flag |

## Verification
The assertions assume the bus master keeps `hwdata` valid for a whole data phase. They also assume `odd_parity` and `fault_inj` are treated as synchronous levels, so the parity checks compare against the previous cycle's select and fault values. The read-back checks rely on `pin_in` being stable across the edge that ends the address phase. The stimulus meets these conditions: inputs change only on the falling clock edge, every bus transfer is a single NONSEQ followed by IDLE, and the pin word and the mode inputs are held for at least one full cycle before any check samples them.

// File: rtl/gpar_pkg.sv
package gpar_pkg;

   localparam int BUS_W = 32;

   // decoded register region of a captured transfer
   typedef enum logic [1:0] {
      RGN_NONE = 2'd0,
      RGN_DATA = 2'd1,
      RGN_DIR  = 2'd2
   } rgn_e;

   // state carried from address phase into data phase
   typedef struct packed {
      logic live;
      logic wr;
      rgn_e rgn;
   } dphase_t;

endpackage

// File: rtl/gpar_ahb_front.sv
module gpar_ahb_front
   import gpar_pkg::*;
#(
   parameter int AW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hsel,
   input  logic [AW-1:0] haddr,
   input  logic [1:0]    htrans,
   input  logic          hwrite,
   input  logic          hready,
   output dphase_t       dp
);

   localparam int WORD_W = AW - 2;

   logic       xfer;
   logic       aligned;
   rgn_e       rgn_d;
   dphase_t    dp_d;

   // only NONSEQ and SEQ carry a transfer
   assign xfer    = hsel && hready && ((htrans == 2'b10) || (htrans == 2'b11));
   assign aligned = (haddr[1:0] == 2'b00);

   always_comb begin
      rgn_d = RGN_NONE;
      if (aligned) begin
         if (haddr[AW-1:2] == WORD_W'(0))      rgn_d = RGN_DATA;
         else if (haddr[AW-1:2] == WORD_W'(1)) rgn_d = RGN_DIR;
      end
   end

   always_comb begin
      dp_d.live = xfer;
      dp_d.wr   = xfer && hwrite;
      dp_d.rgn  = xfer ? rgn_d : RGN_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dp <= '{live: 1'b0, wr: 1'b0, rgn: RGN_NONE};
      end else if (hready) begin
         dp <= dp_d;
      end
   end

endmodule

// File: rtl/gpar_parity_gen.sv
module gpar_parity_gen #(
   parameter int W     = 16,
   parameter bit CHAIN = 1'b0
) (
   input  logic [W-1:0] d,
   input  logic         odd_sel,
   input  logic         invert,
   output logic         par
);

   generate
      if (CHAIN) begin : g_chain
         logic [W:0] acc;
         assign acc[0] = odd_sel ^ invert;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign acc[i+1] = acc[i] ^ d[i];
         end
         assign par = acc[W];
      end else begin : g_tree
         assign par = (^d) ^ odd_sel ^ invert;
      end
   endgenerate

endmodule

// File: rtl/gpar_core.sv
module gpar_core
   import gpar_pkg::*;
#(
   parameter int DW    = 16,
   parameter bit CHAIN = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  dphase_t          dp,
   input  logic [BUS_W-1:0] hwdata,
   input  logic             odd_sel,
   input  logic             fault,
   input  logic [DW:0]      pin_in,
   output logic [BUS_W-1:0] rdata,
   output logic [DW:0]      pin_out,
   output logic             oe,
   output logic             perr
);

   logic [DW-1:0] out_q, out_d;
   logic          tx_par_q, tx_par_d;
   logic          dir_q;
   logic [DW-1:0] in_q;
   logic          rx_calc;
   logic          perr_q;
   logic          wr_data_ok, wr_dir;

   assign wr_data_ok = dp.live && dp.wr && (dp.rgn == RGN_DATA) && dir_q;
   assign wr_dir     = dp.live && dp.wr && (dp.rgn == RGN_DIR);
   assign out_d      = wr_data_ok ? hwdata[DW-1:0] : out_q;

   // parity of the word that will be driven after this edge
   gpar_parity_gen #(.W(DW), .CHAIN(CHAIN)) u_tx_par (
      .d       (out_d),
      .odd_sel (odd_sel),
      .invert  (fault),
      .par     (tx_par_d)
   );

   // expected parity of the arriving word
   gpar_parity_gen #(.W(DW), .CHAIN(CHAIN)) u_rx_par (
      .d       (pin_in[DW-1:0]),
      .odd_sel (odd_sel),
      .invert  (1'b0),
      .par     (rx_calc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q    <= '0;
         tx_par_q <= 1'b0;
         dir_q    <= 1'b0;
         in_q     <= '0;
         perr_q   <= 1'b0;
      end else begin
         out_q    <= out_d;
         tx_par_q <= tx_par_d;
         in_q     <= pin_in[DW-1:0];
         perr_q   <= (rx_calc ^ pin_in[DW]) ^ fault;
         if (wr_dir) dir_q <= hwdata[0];
      end
   end

   always_comb begin
      rdata = '0;
      if (dp.live && !dp.wr) begin
         unique case (dp.rgn)
            RGN_DATA: rdata[DW-1:0] = dir_q ? out_q : in_q;
            RGN_DIR:  rdata[0]      = dir_q;
            default:  rdata         = '0;
         endcase
      end
   end

   assign pin_out = {tx_par_q, out_q};
   assign oe      = dir_q;
   assign perr    = perr_q;

   generate
      if (DW < BUS_W) begin : g_spare
         logic unused_hwdata_hi;
         assign unused_hwdata_hi = ^hwdata[BUS_W-1:DW];
      end
   endgenerate

endmodule

// File: rtl/gpio_parity_ahb.sv
module gpio_parity_ahb
   import gpar_pkg::*;
#(
   parameter int DW    = 16,
   parameter int AW    = 12,
   parameter bit CHAIN = 1'b0
) (
   input  logic             hclk,
   input  logic             hresetn,
   input  logic             hsel,
   input  logic [AW-1:0]    haddr,
   input  logic [1:0]       htrans,
   input  logic             hwrite,
   input  logic             hready,
   input  logic [31:0]      hwdata,
   output logic [31:0]      hrdata,
   output logic             hreadyout,
   output logic             hresp,
   input  logic             odd_parity,
   input  logic             fault_inj,
   input  logic [DW:0]      pin_in,
   output logic [DW:0]      pin_out,
   output logic             pin_oe,
   output logic             parity_err
);

   generate
      if (DW < 1 || DW > BUS_W) begin : g_bad_dw
         $error("gpio_parity_ahb: DW must lie in 1..32");
      end
      if (AW < 3 || AW > 32) begin : g_bad_aw
         $error("gpio_parity_ahb: AW must lie in 3..32");
      end
   endgenerate

   dphase_t dp;

   gpar_ahb_front #(.AW(AW)) u_front (
      .clk    (hclk),
      .rst_n  (hresetn),
      .hsel   (hsel),
      .haddr  (haddr),
      .htrans (htrans),
      .hwrite (hwrite),
      .hready (hready),
      .dp     (dp)
   );

   gpar_core #(.DW(DW), .CHAIN(CHAIN)) u_core (
      .clk     (hclk),
      .rst_n   (hresetn),
      .dp      (dp),
      .hwdata  (hwdata),
      .odd_sel (odd_parity),
      .fault   (fault_inj),
      .pin_in  (pin_in),
      .rdata   (hrdata),
      .pin_out (pin_out),
      .oe      (pin_oe),
      .perr    (parity_err)
   );

   assign hreadyout = 1'b1;
   assign hresp     = 1'b0;

endmodule

// File: rtl/gpio_parity_ahb_chk.sv
module gpio_parity_ahb_chk #(
   parameter int DW = 16,
   parameter int AW = 12
) (
   input logic          hclk,
   input logic          hresetn,
   input logic          hsel,
   input logic [AW-1:0] haddr,
   input logic [1:0]    htrans,
   input logic          hwrite,
   input logic          hready,
   input logic [31:0]   hwdata,
   input logic [31:0]   hrdata,
   input logic          hreadyout,
   input logic          hresp,
   input logic          odd_parity,
   input logic          fault_inj,
   input logic [DW:0]   pin_in,
   input logic [DW:0]   pin_out,
   input logic          pin_oe,
   input logic          parity_err
);

   logic ok_q;
   logic c_wr_data, c_rd_dir, c_rd_none;
   logic act;
   logic unused_chk;

   assign act        = hsel && hready && htrans[1];
   assign unused_chk = hreadyout ^ hresp;

   always_ff @(posedge hclk or negedge hresetn) begin
      if (!hresetn) begin
         ok_q      <= 1'b0;
         c_wr_data <= 1'b0;
         c_rd_dir  <= 1'b0;
         c_rd_none <= 1'b0;
      end else begin
         ok_q      <= 1'b1;
         c_wr_data <= act && hwrite && (haddr == AW'(0));
         c_rd_dir  <= act && !hwrite && (haddr == AW'(4));
         c_rd_none <= act && !hwrite && (haddr != AW'(0)) && (haddr != AW'(4));
      end
   end

   AST_TX_PARITY: assert property (@(posedge hclk) disable iff (!hresetn)
      ok_q |-> (pin_out[DW] == ((^pin_out[DW-1:0]) ^ $past(odd_parity) ^ $past(fault_inj)))); // R3 R4

   AST_RX_ERROR: assert property (@(posedge hclk) disable iff (!hresetn)
      ok_q |-> (parity_err == ((^$past(pin_in)) ^ $past(odd_parity) ^ $past(fault_inj)))); // R5

   AST_WRITE_LANDS: assert property (@(posedge hclk) disable iff (!hresetn)
      (ok_q && $past(c_wr_data && pin_oe)) |-> (pin_out[DW-1:0] == $past(hwdata[DW-1:0]))); // R6

   AST_OUT_HOLDS: assert property (@(posedge hclk) disable iff (!hresetn)
      (ok_q && !$past(c_wr_data)) |-> $stable(pin_out[DW-1:0])); // R7

   AST_DIR_READBACK: assert property (@(posedge hclk) disable iff (!hresetn)
      c_rd_dir |-> (hrdata == {31'b0, pin_oe})); // R8

   AST_UNMAPPED_ZERO: assert property (@(posedge hclk) disable iff (!hresetn)
      c_rd_none |-> (hrdata == 32'b0)); // R10

endmodule

bind gpio_parity_ahb gpio_parity_ahb_chk #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/sim_gpio_parity_ahb.sv
`timescale 1ns/1ps
module sim_gpio_parity_ahb;

   localparam int DW = 16;
   localparam int AW = 12;

   logic          hclk = 1'b0;
   logic          hresetn = 1'b0;
   logic          hsel = 1'b0;
   logic [AW-1:0] haddr = '0;
   logic [1:0]    htrans = 2'b00;
   logic          hwrite = 1'b0;
   logic          hready = 1'b1;
   logic [31:0]   hwdata = '0;
   logic [31:0]   hrdata;
   logic          hreadyout, hresp;
   logic          odd_parity = 1'b0;
   logic          fault_inj = 1'b0;
   logic [DW:0]   pin_in = '0;
   logic [DW:0]   pin_out;
   logic          pin_oe, parity_err;

   int n_cmp = 0;
   int n_bad = 0;
   logic          m_dir = 1'b0;
   logic [DW-1:0] m_out = '0;
   bit            done = 1'b0;

   always #5 hclk = ~hclk;

   gpio_parity_ahb #(.DW(DW), .AW(AW)) u0 (.*);

   function automatic logic exp_tx_par(logic [DW-1:0] d, logic o, logic f);
      return (^d) ^ o ^ f;
   endfunction

   function automatic logic exp_err(logic [DW:0] w, logic o, logic f);
      return (^w) ^ o ^ f;
   endfunction

   task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
      end
   endtask

   task automatic bus_write(logic [AW-1:0] a, logic [31:0] d, logic [1:0] tr = 2'b10);
      @(negedge hclk);
      hsel = 1'b1; haddr = a; htrans = tr; hwrite = 1'b1;
      @(negedge hclk);
      hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0; hwdata = d;
      @(negedge hclk);
      hwdata = $urandom;
   endtask

   task automatic bus_read(logic [AW-1:0] a, output logic [31:0] d);
      @(negedge hclk);
      hsel = 1'b1; haddr = a; htrans = 2'b10; hwrite = 1'b0;
      @(negedge hclk);
      hsel = 1'b0; htrans = 2'b00;
      d = hrdata;
   endtask

   task automatic set_mode(logic o, logic f);
      @(negedge hclk);
      odd_parity = o; fault_inj = f;
      @(negedge hclk);
   endtask

   task automatic chk_out(string req);
      chk({req, " data"}, 32'(pin_out[DW-1:0]), 32'(m_out));
      chk({req, " parity"}, 32'(pin_out[DW]), 32'(exp_tx_par(m_out, odd_parity, fault_inj)));
   endtask

   task automatic drive_in(logic [DW:0] w);
      @(negedge hclk);
      pin_in = w;
      @(negedge hclk);
      chk("R5 parity_err", 32'(parity_err), 32'(exp_err(w, odd_parity, fault_inj)));
   endtask

   task automatic do_write_data(logic [31:0] d);
      bus_write(AW'(0), d);
      if (m_dir) m_out = d[DW-1:0];
      chk_out(m_dir ? "R6" : "R7");
   endtask

   task automatic do_write_dir(logic [31:0] d);
      logic [31:0] rd;
      bus_write(AW'(4), d);
      m_dir = d[0];
      chk("R8 pin_oe", 32'(pin_oe), 32'(m_dir));
      bus_read(AW'(4), rd);
      chk("R8 dir read", rd, 32'(m_dir));
   endtask

   task automatic do_read_data();
      logic [31:0] rd;
      bus_read(AW'(0), rd);
      chk("R9 data read", rd, m_dir ? 32'(m_out) : 32'(pin_in[DW-1:0]));
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge hclk);
      // R2 reset state
      chk("R2 pin_out", 32'(pin_out), 32'(0));
      chk("R2 pin_oe", 32'(pin_oe), 32'(0));
      chk("R2 parity_err", 32'(parity_err), 32'(0));
      hresetn = 1'b1;
      @(negedge hclk);
      chk("R1 hreadyout", 32'(hreadyout), 32'(1));
      chk("R1 hresp", 32'(hresp), 32'(0));

      // R7: write while input direction is ignored, stays hidden after switch
      do_write_data(32'h0000_A5A5);
      do_write_dir(32'h1);
      chk_out("R7 after dir switch");
      do_write_data(32'hFFFF_1234);
      // R3/R4 mode sweep on the held word
      set_mode(1'b1, 1'b0); chk_out("R3 odd");
      set_mode(1'b0, 1'b1); chk_out("R4 fault even");
      set_mode(1'b1, 1'b1); chk_out("R4 fault odd");
      set_mode(1'b0, 1'b0); chk_out("R3 even");

      // R10 unmapped offsets
      bus_read(AW'(8), rd);  chk("R10 read 0x8", rd, 32'(0));
      bus_read(AW'(3), rd);  chk("R10 read misaligned", rd, 32'(0));
      bus_write(AW'(8), 32'h0000_0F0F); chk_out("R10 write 0x8");
      bus_write(AW'(1), 32'h0000_0F0F); chk_out("R10 write misaligned");
      // R11 IDLE and BUSY carry no transfer
      bus_write(AW'(0), 32'h0000_3333, 2'b00); chk_out("R11 idle");
      bus_write(AW'(0), 32'h0000_3333, 2'b01); chk_out("R11 busy");
      bus_write(AW'(4), 32'h0000_0000, 2'b00);
      chk("R11 dir kept", 32'(pin_oe), 32'(1));

      // R5 directed: clean and corrupted words
      drive_in({1'b0, 16'h0000});
      drive_in({1'b1, 16'h0000});
      set_mode(1'b0, 1'b1);
      drive_in({1'b1, 16'h0001});
      set_mode(1'b0, 1'b0);

      // constrained random mix
      for (int i = 0; i < 300; i++) begin
         int op;
         op = int'($urandom_range(0, 5));
         case (op)
            0: do_write_data($urandom);
            1: do_write_dir({31'($urandom), 1'($urandom)});
            2: do_read_data();
            3: drive_in(17'($urandom));
            4: begin
               set_mode(1'($urandom), ($urandom_range(0, 3) == 0));
               chk_out("R3 R4 random mode");
            end
            default: begin
               bus_read(AW'(4 * $urandom_range(2, 200)), rd);
               chk("R10 random unmapped", rd, 32'(0));
            end
         endcase
         chk("R1 hreadyout", 32'(hreadyout), 32'(1));
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule